// File: doc/BRIEF.md
# Receive 64B/66B and 64B/67B Gearbox with Bit Slip

This block sits behind a receive deserializer. Every clock cycle it takes one word of raw received bits, either 16 or 32 bits wide, at a fixed rate. From that stream it cuts blocks of 64 payload bits, each led by a 2-bit header (64B/66B) or a 3-bit header (64B/67B). Each block is presented on a user word of the same width. The header comes out beside the first word of its block. Because a block carries more bits than its payload words, the output word rate is slightly lower than the input rate. The gearbox therefore inserts a non-valid cycle whenever the bits buffered so far cannot fill the next header word.

Block lock is found by fabric logic outside this block. That logic pulses the slip input, and each cycle with slip high discards one received bit, which moves every later block boundary by one bit. A slip takes effect a fixed, parameterised number of cycles after it is sampled. A start-of-sequence flag marks the first block of each repeat period of the gap pattern. It is driven only in the modes that use the internal sequence counter.

Top module: `gbx_rx_top`

## Requirements
- R1: The interface width parameter DW accepts 16 or 32 only. Any other value stops elaboration with an error.
- R2: Bit 0 of `raw_in` is the earliest received bit. A block is H header bits followed by 64 payload bits. The payload leaves on 64/DW consecutive valid words, and bit 0 of `data_out` is the earliest payload bit of that word.
- R3: The first received header bit of a block appears on `hdr_out[0]`. In 64B/66B modes H is 2 and `hdr_out[2]` reads 0. In 64B/67B modes H is 3 and all three bits carry the header.
- R4: `mode` is decoded as follows. Bit 0 set selects 64B/66B and bit 0 clear selects 64B/67B. Bit 1 set selects the internal sequence counter, so 000 is 67/external, 001 is 66/external, 010 is 67/internal and 011 is 66/internal. Any value with bit 2 set holds the gearbox idle, with all flags low.
- R5: `hdr_valid` is high only together with `data_valid`, and only on the first word of a block. That is every 2nd valid word at DW=32 and every 4th at DW=16.
- R6: Each active cycle adds DW bits to the buffer. A word is emitted when enough bits are buffered: DW+H for a header word, DW otherwise. When there are too few, the cycle is non-valid. Without slips and after start-up, this gives 1 idle cycle per 33 in 64B/66B and 3 idle cycles per 67 in 64B/67B, at either width.
- R7: In internal-counter modes, `seq_start` is high on the header word of every block whose index, counted from enable, is 0 modulo the pattern period. The period is DW/2 blocks for 64B/66B and DW blocks for 64B/67B. In external-counter modes `seq_start` stays 0.
- R8: Each cycle in which `slip` is sampled high discards exactly one received bit. Holding it high for N cycles discards N bits.
- R9: A slip sampled at clock edge k first affects the word registered at edge k+SLIP_LAT-1. That word appears on the outputs SLIP_LAT cycles after the slip is applied, counting the same way as `raw_in` sampled at edge k appearing after edge k.
- R10: While `en` is low, the flags are low from the next edge and the buffer, counters and pending slips are cleared. Raising `en` again restarts exactly as after reset. The first header word appears on the second active cycle.
- R11: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Gearbox enable |
| mode | input | 3 | Header length and sequence counter select |
| slip | input | 1 | Discard one received bit per high cycle |
| raw_in | input | DW | Raw received bits, bit 0 earliest |
| data_out | output | DW | Payload word |
| hdr_out | output | 3 | Block header, valid with hdr_valid |
| data_valid | output | 1 | data_out holds a new word |
| hdr_valid | output | 1 | hdr_out belongs to the current block |
| seq_start | output | 1 | First block of a sequence period |

## Verification
The bench builds two copies side by side and drives them with the same controls. One is 32 bits wide with the default slip latency of 2. The other is 16 bits wide with a latency of 3. This covers both word counts per block, both pattern periods, and a slip delay line with more than one stage. Long runs of isolated and held slips push the block boundary through more than a full block of offsets. As a result, idle cycles fall both on header words and on payload words that slips have starved.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  localparam int unsigned HDR_MAX = 3;
  localparam int unsigned PAYLOAD_BITS = 64;

  typedef enum logic [2:0] {
    GM_67_EXT = 3'b000,
    GM_66_EXT = 3'b001,
    GM_67_INT = 3'b010,
    GM_66_INT = 3'b011
  } gbx_mode_e;

  function automatic int unsigned hdr_len(logic is66);
    return is66 ? 2 : 3;
  endfunction
endpackage

// File: rtl/gbx_slip_dly.sv
module gbx_slip_dly #(
  parameter int unsigned LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic slip_i,
  output logic slip_o
);
  generate
    if (LAT <= 1) begin : g_pass
      assign slip_o = slip_i;
    end else begin : g_pipe
      localparam int unsigned D = LAT - 1;
      logic [D-1:0] sr_q, sr_n;

      always_comb begin
        sr_n[0] = slip_i;
        for (int i = 1; i < D; i++) sr_n[i] = sr_q[i-1];
        if (clr) sr_n = '0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_n;
      end

      assign slip_o = sr_q[D-1];
    end
  endgenerate
endmodule

// File: rtl/gbx_seq.sv
module gbx_seq #(
  parameter int unsigned DW = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  input  logic is66,
  output logic first_word,
  output logic blk_zero
);
  localparam int unsigned WPB = gbx_pkg::PAYLOAD_BITS / DW;
  localparam int unsigned WIW = (WPB > 1) ? $clog2(WPB) : 1;
  localparam int unsigned BCW = $clog2(DW);

  logic [WIW-1:0] wi_q, wi_n;
  logic [BCW-1:0] bc_q, bc_n, bc_last;

  assign bc_last = is66 ? BCW'(DW/2 - 1) : BCW'(DW - 1);

  always_comb begin
    wi_n = wi_q;
    bc_n = bc_q;
    if (clr) begin
      wi_n = '0;
      bc_n = '0;
    end else if (adv) begin
      if (wi_q == WIW'(WPB - 1)) begin
        wi_n = '0;
        bc_n = (bc_q == bc_last) ? '0 : bc_q + 1'b1;
      end else begin
        wi_n = wi_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wi_q <= '0;
      bc_q <= '0;
    end else begin
      wi_q <= wi_n;
      bc_q <= bc_n;
    end
  end

  assign first_word = (wi_q == '0);
  assign blk_zero   = (bc_q == '0);
endmodule

// File: rtl/gbx_bitbuf.sv
module gbx_bitbuf #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [DW-1:0] din,
  input  logic          slip,
  input  logic          is66,
  input  logic          first_word,
  output logic          fire,
  output logic [2:0]    hdr_o,
  output logic [DW-1:0] dat_o
);
  localparam int unsigned BUFW = 2*DW + gbx_pkg::HDR_MAX;
  localparam int unsigned LVW  = $clog2(BUFW + 1);

  logic [BUFW-1:0] bits_q, bits_n, merged;
  logic [LVW-1:0]  lvl_q, lvl_n, lvl_b, need;

  always_comb begin
    merged = bits_q | (BUFW'(din) << lvl_q);
    lvl_b  = lvl_q + LVW'(DW);
    if (slip) begin
      merged = merged >> 1;
      lvl_b  = lvl_b - 1'b1;
    end
    need = first_word ? LVW'(DW) + LVW'(gbx_pkg::hdr_len(is66)) : LVW'(DW);
    fire = (lvl_b >= need);

    hdr_o = {is66 ? 1'b0 : merged[2], merged[1:0]};
    if (!first_word) dat_o = merged[DW-1:0];
    else if (is66)   dat_o = merged[2 +: DW];
    else             dat_o = merged[3 +: DW];

    if (fire) begin
      bits_n = merged >> need;
      lvl_n  = lvl_b - need;
    end else begin
      bits_n = merged;
      lvl_n  = lvl_b;
    end
    if (clr) begin
      bits_n = '0;
      lvl_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      lvl_q  <= '0;
    end else begin
      bits_q <= bits_n;
      lvl_q  <= lvl_n;
    end
  end
endmodule

// File: rtl/gbx_rx_top.sv
module gbx_rx_top #(
  parameter int unsigned DW       = 32,
  parameter int unsigned SLIP_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    mode,
  input  logic          slip,
  input  logic [DW-1:0] raw_in,
  output logic [DW-1:0] data_out,
  output logic [2:0]    hdr_out,
  output logic          data_valid,
  output logic          hdr_valid,
  output logic          seq_start
);
  // R1: only 2-byte and 4-byte user widths are legal
  generate
    if (!(DW == 16 || DW == 32)) begin : g_bad_width
      $error("gbx_rx_top: DW must be 16 or 32");
    end
  endgenerate

  logic active, clr, is66, slip_eff, fire, first_word, blk_zero, take;
  logic [2:0]    hdr_c, hdr_q, hdr_n;
  logic [DW-1:0] dat_c, dat_q, dat_n;
  logic          dv_q, dv_n, hv_q, hv_n, ss_q, ss_n;

  assign active = en & ~mode[2];
  assign clr    = ~active;
  assign is66   = mode[0];

  gbx_slip_dly #(.LAT(SLIP_LAT)) u_sdly (
    .clk(clk), .rst_n(rst_n), .clr(clr), .slip_i(slip), .slip_o(slip_eff)
  );

  gbx_bitbuf #(.DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(clr), .din(raw_in), .slip(slip_eff & active),
    .is66(is66), .first_word(first_word), .fire(fire), .hdr_o(hdr_c), .dat_o(dat_c)
  );

  gbx_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(take), .is66(is66),
    .first_word(first_word), .blk_zero(blk_zero)
  );

  assign take = active & fire;

  always_comb begin
    dv_n  = take;
    hv_n  = take & first_word;
    ss_n  = take & first_word & blk_zero & mode[1];
    dat_n = take ? dat_c : dat_q;
    hdr_n = (take & first_word) ? hdr_c : hdr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      hv_q  <= 1'b0;
      ss_q  <= 1'b0;
      dat_q <= '0;
      hdr_q <= '0;
    end else begin
      dv_q  <= dv_n;
      hv_q  <= hv_n;
      ss_q  <= ss_n;
      dat_q <= dat_n;
      hdr_q <= hdr_n;
    end
  end

  assign data_out   = dat_q;
  assign hdr_out    = hdr_q;
  assign data_valid = dv_q;
  assign hdr_valid  = hv_q;
  assign seq_start  = ss_q;
endmodule

// File: rtl/gbx_rx_chk.sv
module gbx_rx_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [2:0]    mode,
  input logic [2:0]    hdr_out,
  input logic          data_valid,
  input logic          hdr_valid,
  input logic          seq_start
);
  assert_hdr_with_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> data_valid);

  assert_seq_on_header_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> hdr_valid);

  assert_seq_internal_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> $past(mode[1]));

  assert_idle_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!data_valid && !hdr_valid && !seq_start));

  assert_bad_mode_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode[2] |=> !data_valid);

  assert_short_header_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && $past(mode[0])) |-> (hdr_out[2] == 1'b0));
endmodule

bind gbx_rx_top gbx_rx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .hdr_out(hdr_out),
  .data_valid(data_valid), .hdr_valid(hdr_valid), .seq_start(seq_start)
);

// File: tb/gbx_rx_top_tb.sv
module gbx_rx_ref #(
  parameter int unsigned DW  = 32,
  parameter int unsigned LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    mode,
  input  logic          slip,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] e_data,
  output logic [2:0]    e_hdr,
  output logic          e_dv,
  output logic          e_hv,
  output logic          e_ss
);
  bit bq[$];
  bit sq[$];
  int word_idx, blk_idx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bq.delete(); sq.delete();
      word_idx = 0; blk_idx = 0;
      e_data <= '0; e_hdr <= '0; e_dv <= 0; e_hv <= 0; e_ss <= 0;
    end else if (!en || mode[2]) begin
      bq.delete(); sq.delete();
      word_idx = 0; blk_idx = 0;
      e_dv <= 0; e_hv <= 0; e_ss <= 0;
    end else begin
      int h, need, period, words;
      bit eff;
      logic [DW-1:0] d;
      logic [2:0] hh;
      h = mode[0] ? 2 : 3;
      words = 64 / DW;
      period = mode[0] ? DW/2 : DW;
      for (int i = 0; i < DW; i++) bq.push_back(din[i]);
      sq.push_back(slip);
      eff = 0;
      if (sq.size() > LAT - 1) eff = sq.pop_front();
      if (eff) void'(bq.pop_front());
      need = (word_idx == 0) ? DW + h : DW;
      if (bq.size() >= need) begin
        hh = '0;
        if (word_idx == 0)
          for (int i = 0; i < h; i++) hh[i] = bq.pop_front();
        for (int i = 0; i < DW; i++) d[i] = bq.pop_front();
        e_data <= d;
        if (word_idx == 0) e_hdr <= hh;
        e_dv <= 1;
        e_hv <= (word_idx == 0);
        e_ss <= (word_idx == 0) && (blk_idx == 0) && mode[1];
        word_idx = word_idx + 1;
        if (word_idx == words) begin
          word_idx = 0;
          blk_idx = (blk_idx + 1) % period;
        end
      end else begin
        e_dv <= 0; e_hv <= 0; e_ss <= 0;
      end
    end
  end
endmodule

module gbx_rx_top_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, en, slip;
  logic [2:0] mode;
  logic [31:0] din_w;
  logic [15:0] din_n;

  logic [31:0] a_data, e_data;
  logic [15:0] b_data, f_data;
  logic [2:0]  a_hdr, b_hdr, e_hdr, f_hdr;
  logic a_dv, a_hv, a_ss, b_dv, b_hv, b_ss;
  logic e_dv, e_hv, e_ss, f_dv, f_hv, f_ss;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit cmp_on = 0, done = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  gbx_rx_top #(.DW(32), .SLIP_LAT(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .slip(slip), .raw_in(din_w),
    .data_out(a_data), .hdr_out(a_hdr), .data_valid(a_dv), .hdr_valid(a_hv), .seq_start(a_ss));
  gbx_rx_top #(.DW(16), .SLIP_LAT(3)) u_dut_n (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .slip(slip), .raw_in(din_n),
    .data_out(b_data), .hdr_out(b_hdr), .data_valid(b_dv), .hdr_valid(b_hv), .seq_start(b_ss));
  gbx_rx_ref #(.DW(32), .LAT(2)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .slip(slip), .din(din_w),
    .e_data(e_data), .e_hdr(e_hdr), .e_dv(e_dv), .e_hv(e_hv), .e_ss(e_ss));
  gbx_rx_ref #(.DW(16), .LAT(3)) u_ref_n (
    .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .slip(slip), .din(din_n),
    .e_data(f_data), .e_hdr(f_hdr), .e_dv(f_dv), .e_hv(f_hv), .e_ss(f_ss));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      check(0, "watchdog", cyc, 100000);
      finish_run();
    end
  end

  // every-cycle comparison against the behavioural model
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      check(a_dv == e_dv, "R6 data_valid w32", a_dv, e_dv);
      check(a_hv == e_hv, "R5 hdr_valid w32", a_hv, e_hv);
      check(a_ss == e_ss, "R7 seq_start w32", a_ss, e_ss);
      if (e_dv) check(a_data == e_data, "R2 R8 R9 data w32", a_data, e_data);
      if (e_hv) check(a_hdr == e_hdr, "R3 R8 header w32", a_hdr, e_hdr);
      check(b_dv == f_dv, "R1 R6 data_valid w16", b_dv, f_dv);
      check(b_hv == f_hv, "R1 R5 hdr_valid w16", b_hv, f_hv);
      check(b_ss == f_ss, "R1 R7 seq_start w16", b_ss, f_ss);
      if (f_dv) check(b_data == f_data, "R1 R2 R9 data w16", b_data, f_data);
      if (f_hv) check(b_hdr == f_hdr, "R1 R3 header w16", b_hdr, f_hdr);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr  = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      din_w = lfsr;
      din_n = lfsr[31:16] ^ lfsr[15:0];
    end
  endtask

  task automatic slip_for(input int n);
    slip = 1'b1;
    step(n);
    slip = 1'b0;
  endtask

  task automatic new_mode(input logic [2:0] m);
    en = 1'b0;
    step(2);
    check(!a_dv && !a_hv && !b_dv, "R10 idle after enable low", {a_dv, a_hv, b_dv}, 0);
    mode = m;
    en = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; slip = 1'b0; mode = 3'b011; din_w = '0; din_n = '0;
    repeat (3) @(negedge clk);
    check({a_data, a_hdr, a_dv, a_hv, a_ss} == '0, "R11 reset w32",
          {a_data, a_hdr, a_dv, a_hv, a_ss}, 0);
    check({b_data, b_hdr, b_dv, b_hv, b_ss} == '0, "R11 reset w16",
          {b_data, b_hdr, b_dv, b_hv, b_ss}, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    step(2);

    // 66, internal counter
    en = 1'b1;
    step(1);
    check(!a_dv, "R10 first active cycle idle", a_dv, 0);
    step(1);
    check(a_dv && a_hv, "R10 header word on second active cycle", {a_dv, a_hv}, 2'b11);
    step(300);
    slip_for(1); step(20);
    slip_for(3); step(40);
    for (int k = 0; k < 70; k++) begin
      slip_for(1); step(2);
    end
    step(100);

    // 67, internal counter
    new_mode(3'b010);
    step(300);
    for (int k = 0; k < 40; k++) begin
      slip_for(2); step(3);
    end
    step(200);

    // 66 and 67, external counter
    new_mode(3'b001);
    step(150);
    slip_for(5); step(80);
    new_mode(3'b000);
    step(150);
    slip_for(1); step(80);

    // reserved mode holds the gearbox idle
    new_mode(3'b101);
    step(20);
    check(!a_dv && !b_dv, "R4 reserved mode idle", {a_dv, b_dv}, 0);

    // slip sampled while disabled is dropped
    en = 1'b0; mode = 3'b011; slip = 1'b1;
    step(3);
    slip = 1'b0;
    en = 1'b1;
    step(200);

    cmp_on = 1'b0;
    finish_run();
  end
endmodule